// File: doc/BRIEF.md
# Parallel EEPROM Host Access Sequencer

This block sits between an on-chip requester and an external byte-wide EEPROM that is wired like a static RAM. It has an address bus, a bidirectional data bus split into out, in and drive-enable, active-low chip, output and write strobes, and a ready/busy input. The requester issues one command at a time over a valid/ready handshake. A command is either a single-byte read or a single-byte write. Every bus timing is a whole number of clock cycles. Each count is derived from the nanosecond figure and the clock-period parameter, rounded up.

A write drives the address and data, then pulses the write strobe. The sequencer then waits for the device to finish its internal program cycle, which can last milliseconds. Completion is found in one of two ways, chosen per command:
- Data polling: the written address is read again and again until bit 7 comes back equal to bit 7 of the written byte.
- Ready/busy polling: the sequencer watches the ready/busy input.

After completion, one more full read checks the stored byte. A watchdog ends the wait if completion never appears. A single-cycle done pulse carries the read data and the error flags.

Top module: `eeprom_host_seq`

## Requirements
- R1: `cmd_ready_o` is high only while no command is in progress. It drops in the cycle after a command is accepted and stays low until the cycle in which `done_o` pulses.
- R2: A read holds the chip strobe and the output strobe low together for exactly ceil(300 ns / CLK_NS) cycles. The data bus is sampled at the end of that window and the sampled byte is returned on `rdata_o`. The output strobe then stays high for at least ceil(60 ns / CLK_NS) cycles before it falls again.
- R3: The write strobe falls only after address and data have been driven, with the chip strobe low and the output strobe high, for at least ceil(10 ns / CLK_NS) cycles. The write strobe is low for exactly ceil(150 ns / CLK_NS) cycles. Data drive and the chip strobe remain for at least ceil(10 ns / CLK_NS) cycles after it rises. The address does not change while the chip strobe is low.
- R4: With `cmd_rdy_mode_i`=0 at acceptance, the written address is read repeatedly until a read returns bit 7 equal to bit 7 of the written byte.
- R5: With `cmd_rdy_mode_i`=1 at acceptance, the sequencer waits ceil(50 ns / CLK_NS) cycles after the write strobe. It then waits for `mem_rdy_i`=1 and performs no read before that.
- R6: Once completion is seen, one further read of the written address is made. `rdata_o` returns that byte, and `verify_err_o`=1 exactly when it differs from the written byte.
- R7: If completion is not seen within TIMEOUT_CYC cycles after the write strobe sequence ends, the command ends with `timeout_o`=1 and `verify_err_o`=0.
- R8: `done_o` is a single-cycle pulse. `rdata_o`, `timeout_o` and `verify_err_o` are valid with it and hold until the next completion.
- R9: `mem_dq_oe_o` is high only while the write strobe sequence is in progress, and never while the output strobe is low.
- R10: During and right after reset, all three strobes are high, `mem_dq_oe_o`=0, `cmd_ready_o`=1 and `done_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Command can be accepted |
| cmd_write_i | input | 1 | 1 = write, 0 = read |
| cmd_addr_i | input | AW | Byte address |
| cmd_wdata_i | input | 8 | Write byte |
| cmd_rdy_mode_i | input | 1 | 1 = ready/busy completion, 0 = data polling |
| done_o | output | 1 | Command finished (one cycle) |
| rdata_o | output | 8 | Byte read (plain or verify read) |
| timeout_o | output | 1 | Completion not seen in time |
| verify_err_o | output | 1 | Verify read differed from written byte |
| mem_addr_o | output | AW | Device address bus |
| mem_dq_o | output | 8 | Data driven to device |
| mem_dq_oe_o | output | 1 | Data drive enable |
| mem_dq_i | input | 8 | Data returned by device |
| mem_ce_no | output | 1 | Chip strobe, active low |
| mem_oe_no | output | 1 | Output strobe, active low |
| mem_we_no | output | 1 | Write strobe, active low |
| mem_rdy_i | input | 1 | Device ready (low while programming) |

## Verification
Writes run against a device model whose busy time is set per case.
- A very short busy time completes polling on the first read.
- A long busy time forces several polls while bit 7 reads inverted, which shows that the loop compares bit 7 rather than stopping after a fixed count.
- The same writes in ready/busy mode must show exactly one read, and that read must come after the device reports ready.
- A device that stores a byte with bit 0 flipped separates the verify check from the polling match.
- A device that never finishes separates the timeout path in both modes.

The model returns a wrong byte until the read window has lasted the full access time. A sample taken one cycle early is therefore caught.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_WSETUP, S_WPULSE, S_WHOLD, S_BWAIT, S_BPOLL, S_RACC, S_RGAP
  } seq_state_e;

  typedef enum logic [1:0] {RK_PLAIN, RK_POLL, RK_VERIFY} rd_kind_e;

  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // r2_/r3_ phase lengths rely on a loaded count reaching zero and staying there
  a_r3_timer_stays_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);
endmodule

// File: rtl/seq_watchdog.sv
module seq_watchdog #(
  parameter int unsigned LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (clear_i)                           cnt_q <= '0;
    else if (run_i && cnt_q != CW'(LIMIT))      cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == CW'(LIMIT));

  a_r7_expiry_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_o && !clear_i) |=> expired_o);
endmodule

// File: rtl/eeprom_host_seq.sv
module eeprom_host_seq
  import eeprom_seq_pkg::*;
#(
  parameter int unsigned AW          = 13,
  parameter int unsigned CLK_NS      = 20,
  parameter int unsigned TIMEOUT_CYC = 200000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cmd_valid_i,
  output logic          cmd_ready_o,
  input  logic          cmd_write_i,
  input  logic [AW-1:0] cmd_addr_i,
  input  logic [7:0]    cmd_wdata_i,
  input  logic          cmd_rdy_mode_i,
  output logic          done_o,
  output logic [7:0]    rdata_o,
  output logic          timeout_o,
  output logic          verify_err_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_dq_o,
  output logic          mem_dq_oe_o,
  input  logic [7:0]    mem_dq_i,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  input  logic          mem_rdy_i
);
  localparam int unsigned T_AS  = ns2cyc(10, CLK_NS);
  localparam int unsigned T_WP  = max2(ns2cyc(150, CLK_NS), ns2cyc(100, CLK_NS));
  localparam int unsigned T_DH  = ns2cyc(10, CLK_NS);
  localparam int unsigned T_ACC = max2(ns2cyc(300, CLK_NS), ns2cyc(150, CLK_NS));
  localparam int unsigned T_OFF = ns2cyc(60, CLK_NS);
  localparam int unsigned T_DB  = ns2cyc(50, CLK_NS);
  localparam int unsigned T_MAX = max2(max2(T_AS, T_WP), max2(max2(T_DH, T_ACC), max2(T_OFF, T_DB)));
  localparam int unsigned TW    = $clog2(T_MAX + 1);
  localparam logic [TW-1:0] L_AS  = TW'(T_AS - 1);
  localparam logic [TW-1:0] L_WP  = TW'(T_WP - 1);
  localparam logic [TW-1:0] L_DH  = TW'(T_DH - 1);
  localparam logic [TW-1:0] L_ACC = TW'(T_ACC - 1);
  localparam logic [TW-1:0] L_OFF = TW'(T_OFF - 1);
  localparam logic [TW-1:0] L_DB  = TW'(T_DB - 1);

  seq_state_e    state_q, state_d;
  rd_kind_e      kind_q, kind_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    wdata_q, wdata_d, rd_q, rd_d, rdata_q, rdata_d;
  logic          wr_q, wr_d, mode_q, mode_d;
  logic          done_q, done_d, tout_q, tout_d, verr_q, verr_d;
  logic          t_ld, t_zero, wd_clr, wd_run, wd_exp;
  logic [TW-1:0] t_val;

  seq_timer #(.W(TW)) u_timer (
    .clk_i, .rst_ni, .load_i(t_ld), .load_val_i(t_val), .zero_o(t_zero)
  );

  seq_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wd (
    .clk_i, .rst_ni, .clear_i(wd_clr), .run_i(wd_run), .expired_o(wd_exp)
  );

  assign wd_run = wr_q && (state_q inside {S_BWAIT, S_BPOLL, S_RACC, S_RGAP});

  always_comb begin
    state_d = state_q; kind_d = kind_q; addr_d = addr_q; wdata_d = wdata_q;
    wr_d = wr_q; mode_d = mode_q; rd_d = rd_q; rdata_d = rdata_q;
    done_d = 1'b0; tout_d = tout_q; verr_d = verr_q;
    t_ld = 1'b0; t_val = '0; wd_clr = 1'b0;
    unique case (state_q)
      S_IDLE: if (cmd_valid_i) begin
        addr_d = cmd_addr_i; wdata_d = cmd_wdata_i;
        wr_d = cmd_write_i; mode_d = cmd_rdy_mode_i; wd_clr = 1'b1;
        t_ld = 1'b1;
        if (cmd_write_i) begin state_d = S_WSETUP; t_val = L_AS; end
        else begin state_d = S_RACC; kind_d = RK_PLAIN; t_val = L_ACC; end
      end
      S_WSETUP: if (t_zero) begin state_d = S_WPULSE; t_ld = 1'b1; t_val = L_WP; end
      S_WPULSE: if (t_zero) begin state_d = S_WHOLD;  t_ld = 1'b1; t_val = L_DH; end
      S_WHOLD: if (t_zero) begin
        t_ld = 1'b1;
        if (mode_q) begin state_d = S_BWAIT; t_val = L_DB; end
        else begin state_d = S_RACC; kind_d = RK_POLL; t_val = L_ACC; end
      end
      S_BWAIT: if (t_zero) state_d = S_BPOLL;
      S_BPOLL: begin
        if (mem_rdy_i) begin
          state_d = S_RACC; kind_d = RK_VERIFY; t_ld = 1'b1; t_val = L_ACC;
        end else if (wd_exp) begin
          state_d = S_IDLE; done_d = 1'b1; tout_d = 1'b1; verr_d = 1'b0; rdata_d = rd_q;
        end
      end
      S_RACC: if (t_zero) begin
        rd_d = mem_dq_i; state_d = S_RGAP; t_ld = 1'b1; t_val = L_OFF;
      end
      S_RGAP: if (t_zero) begin
        if (kind_q == RK_POLL) begin
          if (rd_q[7] == wdata_q[7]) begin
            state_d = S_RACC; kind_d = RK_VERIFY; t_ld = 1'b1; t_val = L_ACC;
          end else if (wd_exp) begin
            state_d = S_IDLE; done_d = 1'b1; tout_d = 1'b1; verr_d = 1'b0; rdata_d = rd_q;
          end else begin
            state_d = S_RACC; t_ld = 1'b1; t_val = L_ACC;
          end
        end else begin
          state_d = S_IDLE; done_d = 1'b1; tout_d = 1'b0; rdata_d = rd_q;
          verr_d = (kind_q == RK_VERIFY) && (rd_q != wdata_q);
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE; kind_q <= RK_PLAIN; addr_q <= '0; wdata_q <= '0;
      wr_q <= 1'b0; mode_q <= 1'b0; rd_q <= '0; rdata_q <= '0;
      done_q <= 1'b0; tout_q <= 1'b0; verr_q <= 1'b0;
    end else begin
      state_q <= state_d; kind_q <= kind_d; addr_q <= addr_d; wdata_q <= wdata_d;
      wr_q <= wr_d; mode_q <= mode_d; rd_q <= rd_d; rdata_q <= rdata_d;
      done_q <= done_d; tout_q <= tout_d; verr_q <= verr_d;
    end
  end

  assign cmd_ready_o  = (state_q == S_IDLE);
  assign done_o       = done_q;
  assign rdata_o      = rdata_q;
  assign timeout_o    = tout_q;
  assign verify_err_o = verr_q;
  assign mem_addr_o   = addr_q;
  assign mem_dq_o     = wdata_q;
  assign mem_dq_oe_o  = state_q inside {S_WSETUP, S_WPULSE, S_WHOLD};
  assign mem_ce_no    = !(state_q inside {S_WSETUP, S_WPULSE, S_WHOLD, S_RACC});
  assign mem_oe_no    = (state_q != S_RACC);
  assign mem_we_no    = (state_q != S_WPULSE);

  a_r1_busy_after_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_ready_o) |=> !cmd_ready_o);
  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_done_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> cmd_ready_o);
  a_r3_we_framed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_oe_no && mem_dq_oe_o));
  a_r3_data_past_we: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (mem_dq_oe_o && !mem_ce_no));
  a_r3_addr_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && !$past(mem_ce_no)) |-> $stable(mem_addr_o));
  a_r9_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_oe_no |-> !mem_dq_oe_o);
  a_r5_no_read_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_BPOLL && !mem_rdy_i) |=> mem_oe_no);
endmodule

// File: tb/tb_eeprom_host_seq.sv
module tb_eeprom_host_seq;
  localparam int AW = 8, CLK_NS = 20, TO = 400;
  localparam int C_AS  = (10 + CLK_NS - 1) / CLK_NS;
  localparam int C_WP  = (150 + CLK_NS - 1) / CLK_NS;
  localparam int C_DH  = (10 + CLK_NS - 1) / CLK_NS;
  localparam int C_ACC = (300 + CLK_NS - 1) / CLK_NS;
  localparam int C_OFF = (60 + CLK_NS - 1) / CLK_NS;

  logic clk = 0, rst_n = 0;
  logic valid = 0, wr = 0, rmode = 0;
  logic [7:0] caddr = 0, cdata = 0;
  logic ready, done, tout, verr, dqoe, ce, oe, we;
  logic [7:0] rdata, maddr, dq_o, dq_in;
  logic rdy_m;
  int nchk = 0, nfail = 0;

  always #10 clk = ~clk;

  eeprom_host_seq #(.AW(AW), .CLK_NS(CLK_NS), .TIMEOUT_CYC(TO)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(valid), .cmd_ready_o(ready),
    .cmd_write_i(wr), .cmd_addr_i(caddr), .cmd_wdata_i(cdata), .cmd_rdy_mode_i(rmode),
    .done_o(done), .rdata_o(rdata), .timeout_o(tout), .verify_err_o(verr),
    .mem_addr_o(maddr), .mem_dq_o(dq_o), .mem_dq_oe_o(dqoe), .mem_dq_i(dq_in),
    .mem_ce_no(ce), .mem_oe_no(oe), .mem_we_no(we), .mem_rdy_i(rdy_m));

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_val(input int i);
    return 8'(i * 37 + 11);
  endfunction

  // device model
  logic [7:0] mem [256];
  logic [7:0] lw_addr = 0, lw_data = 0, tv;
  logic pend = 0, p_we_m = 1;
  int busy_left = 0, busy_len = 10, low_cnt = 0;
  bit stuck = 0, corrupt = 0;
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = init_val(i);
    rdy_m = 1;
  end

  always @(posedge clk) begin
    p_we_m <= we;
    if (!ce && !oe) low_cnt <= low_cnt + 1; else low_cnt <= 0;
    if (p_we_m && !we && !ce) lw_addr <= maddr;
    if (!p_we_m && we && !ce) begin
      lw_data <= dq_o; pend <= 1; rdy_m <= 0; busy_left <= busy_len;
    end else if (pend && !stuck) begin
      if (busy_left <= 1) begin
        mem[lw_addr] <= lw_data ^ (corrupt ? 8'h01 : 8'h00);
        pend <= 0; rdy_m <= 1;
      end else busy_left <= busy_left - 1;
    end
  end

  always_comb begin
    tv = (pend && maddr == lw_addr) ? {~lw_data[7], mem[maddr][6:0]} : mem[maddr];
    if (ce || oe) dq_in = 8'hA5;
    else dq_in = (low_cnt >= C_ACC - 1) ? tv : ~tv;
  end

  // bus monitor, every clock
  logic p_we = 1, p_oe = 1, p_dqoe = 0;
  int we_low = 0, oe_low = 0, since_oe_hi = 100, since_we_rise = 100, setup_cnt = 0;
  int reads = 0;
  bit in_wait = 0, read_in_wait = 0;
  always @(negedge clk) if (rst_n) begin
    chk(!(dqoe && !oe), "R9", "drive while output strobe low", dqoe, 0);
    if (p_we && !we) begin
      chk(setup_cnt >= C_AS && oe && !ce, "R3", "setup cycles before write strobe", setup_cnt, C_AS);
      we_low = 0;
    end
    if (!we) we_low++;
    if (!p_we && we) begin
      chk(we_low == C_WP, "R3", "write strobe width", we_low, C_WP);
      since_we_rise = 0;
      if (rmode) begin in_wait = 1; read_in_wait = 0; end
    end else since_we_rise++;
    if (p_dqoe && !dqoe)
      chk(since_we_rise >= C_DH, "R3", "data hold after write strobe", since_we_rise, C_DH);
    if (!ce && we && dqoe) setup_cnt++; else if (ce) setup_cnt = 0;
    if (p_oe && !oe) begin
      chk(since_oe_hi >= C_OFF, "R2", "float gap before read", since_oe_hi, C_OFF);
      reads++; oe_low = 1;
      if (in_wait) read_in_wait = 1;
    end else if (!oe) oe_low++;
    if (!p_oe && oe) begin
      chk(oe_low == C_ACC, "R2", "read window length", oe_low, C_ACC);
      since_oe_hi = 1;
    end else if (oe) since_oe_hi++;
    if (in_wait && rdy_m && we) begin
      in_wait = 0;
      chk(!read_in_wait, "R5", "read issued while busy", read_in_wait, 0);
    end
    p_we = we; p_oe = oe; p_dqoe = dqoe;
  end

  task automatic run_cmd(input bit w, input logic [7:0] a, input logic [7:0] d, input bit m,
                         output logic [7:0] rd, output bit t, output bit v, output int lat);
    bit bad_ready = 0;
    @(negedge clk);
    while (!ready) @(negedge clk);
    wr = w; caddr = a; cdata = d; rmode = m; reads = 0; valid = 1;
    @(negedge clk);
    valid = 0; lat = 1;
    while (!done && lat < 5000) begin
      if (ready) bad_ready = 1;
      @(negedge clk); lat++;
    end
    chk(!bad_ready, "R1", "ready high while busy", bad_ready, 0);
    rd = rdata; t = tout; v = verr;
    @(negedge clk);
    chk(!done, "R8", "done longer than one cycle", done, 0);
    chk(rdata == rd && tout == t && verr == v, "R8", "result held after done", rdata, rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] rd; bit t, v; int lat;
    repeat (3) @(negedge clk);
    chk(ce && oe && we && !dqoe && ready && !done, "R10", "reset state", {ce, oe, we, dqoe, ready, done}, 6'b111010);
    rst_n = 1;
    @(negedge clk);
    chk(ce && oe && we && !dqoe && ready && !done, "R10", "state after reset", {ce, oe, we, dqoe, ready, done}, 6'b111010);

    run_cmd(0, 8'h05, 0, 0, rd, t, v, lat);
    chk(rd == init_val(5), "R2", "plain read data", rd, init_val(5));
    chk(reads == 1 && !t && !v, "R2", "plain read single access", reads, 1);

    busy_len = 40;
    run_cmd(1, 8'h10, 8'hC3, 0, rd, t, v, lat);
    chk(reads >= 3, "R4", "polls while bit 7 inverted", reads, 3);
    chk(rd == 8'hC3 && !v && !t, "R6", "verify byte after polling", rd, 8'hC3);
    run_cmd(0, 8'h10, 0, 0, rd, t, v, lat);
    chk(rd == 8'hC3, "R2", "readback of written byte", rd, 8'hC3);

    busy_len = 2;
    run_cmd(1, 8'h20, 8'h3C, 0, rd, t, v, lat);
    chk(reads == 2, "R4", "first poll matches then verify", reads, 2);
    chk(rd == 8'h3C && !v, "R6", "verify byte short busy", rd, 8'h3C);

    busy_len = 60;
    run_cmd(1, 8'h21, 8'h81, 1, rd, t, v, lat);
    chk(reads == 1, "R5", "only verify read in ready/busy mode", reads, 1);
    chk(lat >= 60, "R5", "waited for ready", lat, 60);
    chk(rd == 8'h81 && !v && !t, "R6", "verify byte ready/busy mode", rd, 8'h81);

    corrupt = 1; busy_len = 10;
    run_cmd(1, 8'h30, 8'h96, 0, rd, t, v, lat);
    chk(v && !t, "R6", "mismatch flagged polling mode", v, 1);
    chk(rd == 8'h97, "R6", "mismatched byte returned", rd, 8'h97);
    run_cmd(1, 8'h31, 8'h14, 1, rd, t, v, lat);
    chk(v && rd == 8'h15, "R6", "mismatch flagged ready/busy mode", rd, 8'h15);
    corrupt = 0;

    stuck = 1;
    run_cmd(1, 8'h40, 8'h55, 0, rd, t, v, lat);
    chk(t && !v, "R7", "timeout polling mode", t, 1);
    chk(lat >= TO && lat <= TO + 40, "R7", "timeout latency polling", lat, TO);
    run_cmd(1, 8'h41, 8'hAA, 1, rd, t, v, lat);
    chk(t && !v, "R7", "timeout ready/busy mode", t, 1);
    chk(lat >= TO && lat <= TO + 40, "R7", "timeout latency ready/busy", lat, TO);
    stuck = 0;
    repeat (20) @(negedge clk);

    run_cmd(0, 8'h07, 0, 0, rd, t, v, lat);
    chk(rd == init_val(7) && !t && !v, "R8", "flags cleared on next command", rd, init_val(7));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule